// File: doc/BRIEF.md
# Single-Entry Data-Cache Store Buffer

This block sits between the load/store pipeline and a synchronous data-cache array that has one write port. A store is presented together with its address, data and byte enables while the cache looks up its tag. One cycle later the tag result arrives, and the store is either written straight into the array or parked in a one-entry buffer built from flip-flops. The buffer also records whether the store hit. A parked entry drains into the array in any cycle in which no load is reading the array. An entry that missed leaves the buffer without writing anything.

Loads read tags and data in the same cycle, so they always take priority over a drain. A load whose word address matches a pending store (either the one in lookup or the one parked in the buffer) receives that store's enabled bytes merged over the array data, one cycle after the load is accepted. A refill notification names the cache line that is being replaced. If that line holds the pending store, the store loses its hit status and never writes the array, so it cannot corrupt the new line. When a second store reaches lookup while the buffer is still full, the block raises a one-cycle stall. During that cycle the old entry drains and the new store takes its place. A build option replaces forwarding with stalling every load while any store is pending.

Top module: `dcsb_top`

## Requirements
- R1: After reset no store is pending, and `stall`, `arr_we` and `ld_rvalid` are low.
- R2: A store whose tag result (`st_hit`, valid in the cycle after `st_valid`) is a hit is written to the array in that same lookup cycle if the buffer is empty and no load is accepted in that cycle. The write uses the store's address, data and byte enables.
- R3: Every store that is not written directly goes into the buffer at the end of its lookup cycle, and the array is not written in that cycle. This covers a miss, an accepted load, and a full buffer.
- R4: A buffered hit entry is written to the array in the first cycle with no accepted load, and the buffer then empties. A buffered miss entry empties in the same way but produces no write.
- R5: The array is never written in a cycle in which a load is accepted (`ld_valid` high and `stall` low).
- R6: When a store is in lookup while the buffer is full, `stall` is high for exactly one cycle. In that cycle the old entry drains and the new store is buffered.
- R7: A replacement (`repl_valid`) whose line index equals address bits [9:4] of the pending store clears that store's hit status, so the store never writes the array. These bit positions follow from the defaults of 16-byte lines and 64 sets. This applies to a store in lookup and to a store in the buffer.
- R8: A replacement of a different line index leaves a buffered hit entry unchanged, and the entry still drains to the array.
- R9: An accepted load raises `ld_rvalid` one cycle later. In `ld_rdata`, every byte whose enable is set in a pending store with the same word address (bits [31:2]) comes from that store, and every other byte comes from `arr_rdata` of that cycle.
- R10: While `stall` is high, `st_valid` and `ld_valid` are ignored and must be presented again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store presented for tag lookup |
| st_addr | input | AW | Store byte address |
| st_data | input | DW | Store data |
| st_be | input | DW/8 | Store byte enables |
| st_hit | input | 1 | Tag result for the store in lookup (cycle after st_valid) |
| ld_valid | input | 1 | Load reading the array this cycle |
| ld_addr | input | AW | Load byte address |
| arr_rdata | input | DW | Array read data, one cycle after the load |
| ld_rvalid | output | 1 | Merged load data valid |
| ld_rdata | output | DW | Load data with pending store bytes merged |
| arr_we | output | 1 | Array write enable |
| arr_waddr | output | AW | Array write byte address |
| arr_wdata | output | DW | Array write data |
| arr_wbe | output | DW/8 | Array write byte enables |
| repl_valid | input | 1 | A refill is replacing a line |
| repl_idx | input | log2(SETS) | Index of the line being replaced |
| stall | output | 1 | Pipeline must hold its current requests |

## Verification
The bound checker watches these rules on every cycle: the array is never written while a load is accepted, a direct write only happens with an empty buffer, a captured store appears in the buffer in the following cycle, a write never goes to the line named by a replacement in the same cycle, a stall always drains and never lasts two cycles, and load data only becomes valid after an accepted load. Some effects can only be shown by the bench scenarios, because a per-cycle rule cannot see them. These are the byte-exact merge of forwarded store data, a replacement silently cancelling a write that would have come several cycles later, an unrelated replacement leaving a write in place, and requests dropped during a stall or lost to a reset.

// File: rtl/dcsb_pkg.sv
package dcsb_pkg;

  // Source driving the single array write port in a cycle.
  typedef enum logic [1:0] {
    WSRC_NONE   = 2'd0,
    WSRC_BYPASS = 2'd1,
    WSRC_DRAIN  = 2'd2
  } wsrc_e;

endpackage

// File: rtl/dcsb_ctrl.sv
module dcsb_ctrl
  import dcsb_pkg::*;
#(
  parameter bit FORWARD = 1'b1
) (
  input  logic  lk_valid,
  input  logic  lk_hit,
  input  logic  lk_repl,
  input  logic  buf_valid,
  input  logic  buf_hit,
  input  logic  buf_repl,
  input  logic  ld_valid,
  output logic  stall,
  output logic  load_go,
  output logic  bypass,
  output logic  drain,
  output logic  capture,
  output logic  cap_hit,
  output wsrc_e wsrc
);

  logic ld_block;

  always_comb begin
    if (FORWARD) ld_block = 1'b0;
    else         ld_block = ld_valid & (lk_valid | buf_valid);
    stall   = (lk_valid & buf_valid) | ld_block;
    load_go = ld_valid & ~stall;
    cap_hit = lk_hit & ~lk_repl;
    bypass  = lk_valid & ~buf_valid & cap_hit & ~load_go;
    capture = lk_valid & ~bypass;
    drain   = buf_valid & ~load_go;
    if (bypass)                            wsrc = WSRC_BYPASS;
    else if (drain & buf_hit & ~buf_repl)  wsrc = WSRC_DRAIN;
    else                                   wsrc = WSRC_NONE;
  end

endmodule

// File: rtl/dcsb_slot.sv
module dcsb_slot #(
  parameter int unsigned AW  = 32,
  parameter int unsigned DW  = 32,
  parameter int unsigned BEW = DW / 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [AW-1:0]  d_addr,
  input  logic [DW-1:0]  d_data,
  input  logic [BEW-1:0] d_be,
  input  logic           d_hit,
  input  logic           release_i,
  input  logic           clr_hit,
  output logic           q_valid,
  output logic [AW-1:0]  q_addr,
  output logic [DW-1:0]  q_data,
  output logic [BEW-1:0] q_be,
  output logic           q_hit
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_addr  <= '0;
      q_data  <= '0;
      q_be    <= '0;
      q_hit   <= 1'b0;
    end else if (load) begin
      q_valid <= 1'b1;
      q_addr  <= d_addr;
      q_data  <= d_data;
      q_be    <= d_be;
      q_hit   <= d_hit;
    end else if (release_i) begin
      q_valid <= 1'b0;
      q_hit   <= 1'b0;
    end else if (clr_hit) begin
      q_hit   <= 1'b0;
    end
  end

endmodule

// File: rtl/dcsb_fwd.sv
module dcsb_fwd #(
  parameter int unsigned DW      = 32,
  parameter int unsigned WW      = 30,
  parameter bit          FORWARD = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_go,
  input  logic [WW-1:0]   ld_word,
  input  logic            lk_valid,
  input  logic [WW-1:0]   lk_word,
  input  logic [DW-1:0]   lk_data,
  input  logic [DW/8-1:0] lk_be,
  input  logic            buf_valid,
  input  logic [WW-1:0]   buf_word,
  input  logic [DW-1:0]   buf_data,
  input  logic [DW/8-1:0] buf_be,
  input  logic [DW-1:0]   arr_rdata,
  output logic            ld_rvalid,
  output logic [DW-1:0]   ld_rdata
);

  localparam int unsigned BEW = DW / 8;

  function automatic logic [DW-1:0] overlay(input logic [DW-1:0] base,
                                            input logic [DW-1:0] over,
                                            input logic [BEW-1:0] be);
    logic [DW-1:0] r;
    r = base;
    for (int i = 0; i < BEW; i++)
      if (be[i]) r[8*i +: 8] = over[8*i +: 8];
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) ld_rvalid <= 1'b0;
    else        ld_rvalid <= load_go;
  end

  generate
    if (FORWARD) begin : g_merge
      logic [BEW-1:0] m_be;
      logic [DW-1:0]  m_data;
      logic [BEW-1:0] be_buf, be_lk;

      always_comb begin
        be_buf = (buf_valid && buf_word == ld_word) ? buf_be : '0;
        be_lk  = (lk_valid  && lk_word  == ld_word) ? lk_be  : '0;
      end

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          m_be   <= '0;
          m_data <= '0;
        end else if (load_go) begin
          m_be   <= be_buf | be_lk;
          m_data <= overlay(overlay('0, buf_data, be_buf), lk_data, be_lk);
        end
      end

      assign ld_rdata = overlay(arr_rdata, m_data, m_be);
    end else begin : g_plain
      logic unused_fwd;
      assign unused_fwd = ^{ld_word, lk_valid, lk_word, lk_data, lk_be,
                            buf_valid, buf_word, buf_data, buf_be};
      assign ld_rdata = arr_rdata;
    end
  endgenerate

endmodule

// File: rtl/dcsb_top.sv
module dcsb_top
  import dcsb_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter int unsigned DW         = 32,
  parameter int unsigned LINE_BYTES = 16,
  parameter int unsigned SETS       = 64,
  parameter bit          FORWARD    = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    st_valid,
  input  logic [AW-1:0]           st_addr,
  input  logic [DW-1:0]           st_data,
  input  logic [DW/8-1:0]         st_be,
  input  logic                    st_hit,
  input  logic                    ld_valid,
  input  logic [AW-1:0]           ld_addr,
  input  logic [DW-1:0]           arr_rdata,
  output logic                    ld_rvalid,
  output logic [DW-1:0]           ld_rdata,
  output logic                    arr_we,
  output logic [AW-1:0]           arr_waddr,
  output logic [DW-1:0]           arr_wdata,
  output logic [DW/8-1:0]         arr_wbe,
  input  logic                    repl_valid,
  input  logic [$clog2(SETS)-1:0] repl_idx,
  output logic                    stall
);

  localparam int unsigned BEW   = DW / 8;
  localparam int unsigned OFFW  = $clog2(BEW);
  localparam int unsigned LINEW = $clog2(LINE_BYTES);
  localparam int unsigned IDXW  = $clog2(SETS);
  localparam int unsigned WW    = AW - OFFW;

  // Lookup stage: the store whose tag is being checked this cycle.
  logic           lk_valid;
  logic [AW-1:0]  lk_addr;
  logic [DW-1:0]  lk_data;
  logic [BEW-1:0] lk_be;

  // Buffered entry.
  logic           buf_valid, buf_hit;
  logic [AW-1:0]  buf_addr;
  logic [DW-1:0]  buf_data;
  logic [BEW-1:0] buf_be;

  // Named internal events.
  logic  load_go, bypass, drain, capture, cap_hit;
  logic  lk_repl, buf_repl;
  wsrc_e wsrc;

  logic [OFFW-1:0] unused_ld_lo;
  assign unused_ld_lo = ld_addr[OFFW-1:0];

  assign lk_repl  = repl_valid && (lk_addr[LINEW +: IDXW]  == repl_idx);
  assign buf_repl = repl_valid && (buf_addr[LINEW +: IDXW] == repl_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_valid <= 1'b0;
      lk_addr  <= '0;
      lk_data  <= '0;
      lk_be    <= '0;
    end else begin
      lk_valid <= st_valid & ~stall;
      if (st_valid & ~stall) begin
        lk_addr <= st_addr;
        lk_data <= st_data;
        lk_be   <= st_be;
      end
    end
  end

  dcsb_ctrl #(.FORWARD(FORWARD)) u_ctrl (
    .lk_valid (lk_valid),
    .lk_hit   (st_hit),
    .lk_repl  (lk_repl),
    .buf_valid(buf_valid),
    .buf_hit  (buf_hit),
    .buf_repl (buf_repl),
    .ld_valid (ld_valid),
    .stall    (stall),
    .load_go  (load_go),
    .bypass   (bypass),
    .drain    (drain),
    .capture  (capture),
    .cap_hit  (cap_hit),
    .wsrc     (wsrc)
  );

  dcsb_slot #(.AW(AW), .DW(DW), .BEW(BEW)) u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (capture),
    .d_addr   (lk_addr),
    .d_data   (lk_data),
    .d_be     (lk_be),
    .d_hit    (cap_hit),
    .release_i(drain),
    .clr_hit  (buf_repl),
    .q_valid  (buf_valid),
    .q_addr   (buf_addr),
    .q_data   (buf_data),
    .q_be     (buf_be),
    .q_hit    (buf_hit)
  );

  always_comb begin
    arr_we    = 1'b0;
    arr_waddr = lk_addr;
    arr_wdata = lk_data;
    arr_wbe   = lk_be;
    unique case (wsrc)
      WSRC_BYPASS: arr_we = 1'b1;
      WSRC_DRAIN: begin
        arr_we    = 1'b1;
        arr_waddr = buf_addr;
        arr_wdata = buf_data;
        arr_wbe   = buf_be;
      end
      default: arr_we = 1'b0;
    endcase
  end

  dcsb_fwd #(.DW(DW), .WW(WW), .FORWARD(FORWARD)) u_fwd (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_go  (load_go),
    .ld_word  (ld_addr[AW-1:OFFW]),
    .lk_valid (lk_valid),
    .lk_word  (lk_addr[AW-1:OFFW]),
    .lk_data  (lk_data),
    .lk_be    (lk_be),
    .buf_valid(buf_valid),
    .buf_word (buf_addr[AW-1:OFFW]),
    .buf_data (buf_data),
    .buf_be   (buf_be),
    .arr_rdata(arr_rdata),
    .ld_rvalid(ld_rvalid),
    .ld_rdata (ld_rdata)
  );

endmodule

// File: rtl/dcsb_chk.sv
module dcsb_chk #(
  parameter int unsigned IDXW = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            stall,
  input logic            ld_valid,
  input logic            ld_rvalid,
  input logic            arr_we,
  input logic [IDXW-1:0] we_idx,
  input logic            repl_valid,
  input logic [IDXW-1:0] repl_idx,
  input logic            lk_valid,
  input logic            buf_valid,
  input logic            bypass,
  input logic            drain,
  input logic            capture
);

  AST_NO_WRITE_UNDER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> !(ld_valid && !stall)); // R5

  AST_BYPASS_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> !buf_valid); // R2

  AST_CAPTURE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> buf_valid); // R3

  AST_NO_WRITE_REPLACED: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> !(repl_valid && we_idx == repl_idx)); // R7

  AST_STALL_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && buf_valid) |-> drain); // R6

  AST_STALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && buf_valid) |=> !(lk_valid && buf_valid)); // R6

  AST_RVALID_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_rvalid |-> $past(ld_valid && !stall)); // R9

endmodule

bind dcsb_top dcsb_chk #(.IDXW(IDXW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .stall     (stall),
  .ld_valid  (ld_valid),
  .ld_rvalid (ld_rvalid),
  .arr_we    (arr_we),
  .we_idx    (arr_waddr[LINEW +: IDXW]),
  .repl_valid(repl_valid),
  .repl_idx  (repl_idx),
  .lk_valid  (lk_valid),
  .buf_valid (buf_valid),
  .bypass    (bypass),
  .drain     (drain),
  .capture   (capture)
);

// File: tb/dcsb_top_tb.sv
module dcsb_top_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        st_valid = 1'b0;
  logic [31:0] st_addr = '0;
  logic [31:0] st_data = '0;
  logic [3:0]  st_be = '0;
  logic        st_hit = 1'b0;
  logic        ld_valid = 1'b0;
  logic [31:0] ld_addr = '0;
  logic [31:0] arr_rdata = '0;
  logic        ld_rvalid;
  logic [31:0] ld_rdata;
  logic        arr_we;
  logic [31:0] arr_waddr;
  logic [31:0] arr_wdata;
  logic [3:0]  arr_wbe;
  logic        repl_valid = 1'b0;
  logic [5:0]  repl_idx = '0;
  logic        stall;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dcsb_top u_dut (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
    .st_hit(st_hit), .ld_valid(ld_valid), .ld_addr(ld_addr),
    .arr_rdata(arr_rdata), .ld_rvalid(ld_rvalid), .ld_rdata(ld_rdata),
    .arr_we(arr_we), .arr_waddr(arr_waddr), .arr_wdata(arr_wdata),
    .arr_wbe(arr_wbe), .repl_valid(repl_valid), .repl_idx(repl_idx),
    .stall(stall)
  );

  typedef struct packed {
    logic       sv;  logic [5:0] sw; logic [3:0] sbe; logic hit;
    logic       lv;  logic [5:0] lw;
    logic       rv;  logic [5:0] ri;
    logic       es;  logic       ewe; logic [5:0] ew;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{1, 1,4'hF,0, 0, 0, 0,0, 0,0, 0},  // 0  store w1
    '{0, 0,4'h0,1, 0, 0, 0,0, 0,1, 1},  // 1  hit, empty, no load: direct
    '{1, 2,4'hF,0, 0, 0, 0,0, 0,0, 0},  // 2  store w2
    '{0, 0,4'h0,0, 1, 5, 0,0, 0,0, 0},  // 3  miss -> buffered
    '{0, 0,4'h0,0, 0, 0, 0,0, 0,0, 0},  // 4  miss drains silently
    '{1, 3,4'hF,0, 0, 0, 0,0, 0,0, 0},  // 5  store w3
    '{0, 0,4'h0,1, 1, 7, 0,0, 0,0, 0},  // 6  hit but load -> buffered
    '{1, 4,4'hF,0, 0, 0, 0,0, 0,1, 3},  // 7  drain w3
    '{0, 0,4'h0,1, 1, 9, 0,0, 0,0, 0},  // 8  w4 buffered
    '{1, 6,4'hF,0, 1,10, 0,0, 0,0, 0},  // 9  load blocks drain
    '{0, 0,4'h0,1, 1,11, 0,0, 1,1, 4},  // 10 full + lookup: stall, drain w4
    '{0, 0,4'h0,0, 0, 0, 0,0, 0,1, 6},  // 11 drain w6
    '{1, 8,4'hF,0, 0, 0, 0,0, 0,0, 0},  // 12 store w8 (line 2)
    '{0, 0,4'h0,1, 0, 0, 1,2, 0,0, 0},  // 13 line 2 replaced in lookup
    '{0, 0,4'h0,0, 0, 0, 0,0, 0,0, 0},  // 14 no write
    '{1,12,4'hF,0, 0, 0, 0,0, 0,0, 0},  // 15 store w12 (line 3)
    '{0, 0,4'h0,1, 1,20, 0,0, 0,0, 0},  // 16 buffered hit
    '{0, 0,4'h0,0, 1,21, 1,3, 0,0, 0},  // 17 line 3 replaced while buffered
    '{0, 0,4'h0,0, 0, 0, 0,0, 0,0, 0},  // 18 drains without write
    '{1,13,4'hF,0, 0, 0, 0,0, 0,0, 0},  // 19 store w13 (line 3)
    '{0, 0,4'h0,1, 1,22, 0,0, 0,0, 0},  // 20 buffered hit
    '{0, 0,4'h0,0, 1,23, 1,5, 0,0, 0},  // 21 other line replaced
    '{0, 0,4'h0,0, 0, 0, 0,0, 0,1,13}   // 22 write still lands
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    st_valid = 0; st_addr = '0; st_data = '0; st_be = '0; st_hit = 0;
    ld_valid = 0; ld_addr = '0; repl_valid = 0; repl_idx = '0; arr_rdata = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle_inputs();
    repeat (3) @(posedge clk);
    @(negedge clk); #2;
    check("R1 stall in reset", stall, 0);
    check("R1 write in reset", arr_we, 0);
    check("R1 rvalid in reset", ld_rvalid, 0);
    rst_n = 1'b1;

    // Vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      idle_inputs();
      st_valid   = VEC[i].sv;
      st_addr    = {24'd0, VEC[i].sw, 2'b00};
      st_data    = 32'hC0DE_0000 | 32'(VEC[i].sw);
      st_be      = VEC[i].sbe;
      st_hit     = VEC[i].hit;
      ld_valid   = VEC[i].lv;
      ld_addr    = {24'd0, VEC[i].lw, 2'b00};
      repl_valid = VEC[i].rv;
      repl_idx   = VEC[i].ri;
      #2;
      check($sformatf("R6 stall row %0d", i), stall, VEC[i].es);
      check($sformatf("R2 R3 R4 R7 R8 write row %0d", i), arr_we, VEC[i].ewe);
      if (VEC[i].ewe) begin
        check($sformatf("R2 R4 waddr row %0d", i), arr_waddr, {24'd0, VEC[i].ew, 2'b00});
        check($sformatf("R2 R4 wdata row %0d", i), arr_wdata, 32'hC0DE_0000 | 32'(VEC[i].ew));
        check($sformatf("R2 R4 wbe row %0d", i), arr_wbe, 4'hF);
      end
    end

    // Forwarding, stall and dropped requests
    @(negedge clk); idle_inputs();
    st_valid = 1; st_addr = 32'd120; st_be = 4'h3; st_data = 32'hAAAA_5566;
    #2; check("R1 idle write", arr_we, 0);

    @(negedge clk); idle_inputs();
    st_hit = 1; ld_valid = 1; ld_addr = 32'd120;
    st_valid = 1; st_addr = 32'd120; st_be = 4'hC; st_data = 32'h7788_BBBB;
    #2;
    check("R3 load forces buffering", arr_we, 0);
    check("R6 no stall when buffer empty", stall, 0);

    @(negedge clk); idle_inputs();
    st_hit = 1; ld_valid = 1; ld_addr = 32'd120; arr_rdata = 32'h1122_3344;
    st_valid = 1; st_addr = 32'd124; st_be = 4'hF; st_data = 32'hDEAD_BEEF;
    #2;
    check("R9 rvalid", ld_rvalid, 1);
    check("R9 merged lookup bytes", ld_rdata, 32'h1122_5566);
    check("R6 stall when full", stall, 1);
    check("R6 drain during stall", arr_we, 1);
    check("R4 drain data", arr_wdata, 32'hAAAA_5566);
    check("R4 drain be", arr_wbe, 4'h3);

    @(negedge clk); idle_inputs();
    st_hit = 1; ld_valid = 1; ld_addr = 32'd120; arr_rdata = 32'h5555_5555;
    #2;
    check("R10 load ignored in stall", ld_rvalid, 0);
    check("R10 store ignored in stall", stall, 0);
    check("R5 no drain while load accepted", arr_we, 0);

    @(negedge clk); idle_inputs();
    arr_rdata = 32'h1122_3344;
    #2;
    check("R9 rvalid buffered", ld_rvalid, 1);
    check("R9 merged buffer bytes", ld_rdata, 32'h7788_3344);
    check("R4 second drain", arr_we, 1);
    check("R4 second drain data", arr_wdata, 32'h7788_BBBB);
    check("R4 second drain be", arr_wbe, 4'hC);

    @(negedge clk); idle_inputs();
    #2; check("R4 buffer empty after drain", arr_we, 0);

    // Reset discards a pending entry
    @(negedge clk); idle_inputs();
    st_valid = 1; st_addr = 32'd160; st_be = 4'hF; st_data = 32'h0BAD_F00D;
    @(negedge clk); idle_inputs();
    st_hit = 1; ld_valid = 1; ld_addr = 32'd0;
    #2; check("R3 buffered before reset", arr_we, 0);
    @(negedge clk); idle_inputs();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    check("R1 no write after reset", arr_we, 0);
    check("R1 no stall after reset", stall, 0);
    check("R1 no rvalid after reset", ld_rvalid, 0);
    @(negedge clk); #2;
    check("R1 entry dropped by reset", arr_we, 0);

    finish_run();
  end

endmodule